// File: doc/BRIEF.md
# Sleep and Watchdog Status Flags

This block holds the 8-bit processor status word. Two of its bits record why the core last came out of reset or sleep. The time-out flag (T) and the power-down flag (P) move only on power-on, watchdog time-out, external reset, sleep-instruction and watchdog-clear events. Firmware reads the pair after start-up to tell a power-up, a watchdog wake-up, a watchdog reset and a reset-pin wake-up apart. Software cannot write either flag.

The same word also carries the carry, digit-carry and zero flags, which the ALU or a software write loads. It holds two register-page select bits and one I/O-control page bit, which are writable and cleared by reset. The word is read combinationally from the registered state. Every event input is a one-cycle pulse sampled on the rising clock edge. `asleep_i` is a level that is high while the core is in sleep mode.

Bit layout, from bit 7 down to bit 0: rpage[1], rpage[0], iopage, T, P, Z, DC, C.

Top module: `status_word_reg`

## Requirements
- R1: After `rst_n` is deasserted, or one cycle after a `por_i` pulse, the read word is 8'h18. In that word T (bit 4) and P (bit 3) are 1 and all other bits are 0.
- R2: One cycle after a watchdog time-out pulse that is not overridden by power-on, T is 0. P is 1 if `asleep_i` was low at that edge and 0 if it was high.
- R3: One cycle after an external reset pulse with `asleep_i` high, and with no power-on or watchdog time-out in the same cycle, T is 1 and P is 0.
- R4: An external reset pulse with `asleep_i` low, and with no power-on or watchdog time-out in the same cycle, leaves T and P unchanged. Any sleep or watchdog-clear instruction in that same cycle is discarded.
- R5: One cycle after a sleep-instruction pulse with no higher-priority event, T is 1 and P is 0.
- R6: One cycle after a watchdog-clear pulse with no higher-priority event, T is 1 and P is 1.
- R7: When several events coincide, T and P follow the first one in this order: power-on, watchdog time-out, external reset, sleep instruction, watchdog-clear instruction.
- R8: A software write never changes T or P, whatever bits 4 and 3 of the written data hold.
- R9: One cycle after a software write with no power-on, bits 7:5 and 2:0 of the word equal the written data. An external reset in the same cycle forces bits 7:5 to 0 instead.
- R10: An ALU flag update loads Z, DC and C from `alu_flags_i[2:0]` (Z in bit 2, C in bit 0). A software write in the same cycle takes precedence.
- R11: An external reset clears bits 7:5 and leaves Z, DC and C unchanged. Power-on clears bits 7:5 and 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, same effect as power-on |
| por_i | input | 1 | Power-on event pulse |
| wdt_to_i | input | 1 | Watchdog time-out pulse |
| ext_rst_i | input | 1 | External reset pin event pulse |
| slp_exec_i | input | 1 | Sleep instruction executed |
| wdtc_exec_i | input | 1 | Watchdog-clear instruction executed |
| asleep_i | input | 1 | High while the core is in sleep mode |
| wr_en_i | input | 1 | Software write strobe for the status word |
| wr_data_i | input | 8 | Software write data |
| alu_we_i | input | 1 | ALU flag update strobe |
| alu_flags_i | input | 3 | New Z, DC, C values (bit 2 to bit 0) |
| rd_data_o | output | 8 | Current status word |

## Verification
A corrupted T or P flip-flop shows up directly in bits 4 and 3 of `rd_data_o`. It is visible on the first read after the faulty edge, because the word is a combinational view of the registers. A wrong priority choice shows only when events coincide. Mixing events randomly with directed collisions therefore exposes it within the cycle after the collision. A write path that leaks into T or P, or that drops a page bit, appears one cycle after the write strobe.

// File: rtl/status_word_pkg.sv
package status_word_pkg;
    localparam int WORD_W   = 8;
    localparam int RPAGE_W  = 2;
    localparam int FLAG_W   = 3;
    localparam int T_POS    = 4;
    localparam int P_POS    = 3;

    typedef struct packed {
        logic [RPAGE_W-1:0] rpage;
        logic               iopage;
        logic               t;
        logic               p;
        logic [FLAG_W-1:0]  zdc_c;
    } stat_word_t;

    localparam logic [WORD_W-1:0] RW_MASK  = ~((8'd1 << T_POS) | (8'd1 << P_POS));
    localparam logic [WORD_W-1:0] TP_RESET = (8'd1 << T_POS) | (8'd1 << P_POS);
endpackage

// File: rtl/status_wake_flags.sv
module status_wake_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic por_i,
    input  logic wdt_to_i,
    input  logic ext_rst_i,
    input  logic slp_exec_i,
    input  logic wdtc_exec_i,
    input  logic asleep_i,
    output logic t_o,
    output logic p_o
);
    typedef struct packed {
        logic t;
        logic p;
    } tp_t;

    tp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (por_i) begin
            st_d = '{t: 1'b1, p: 1'b1};
        end else if (wdt_to_i) begin
            st_d = '{t: 1'b0, p: ~asleep_i};
        end else if (ext_rst_i) begin
            if (asleep_i) st_d = '{t: 1'b1, p: 1'b0};
        end else if (slp_exec_i) begin
            st_d = '{t: 1'b1, p: 1'b0};
        end else if (wdtc_exec_i) begin
            st_d = '{t: 1'b1, p: 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{t: 1'b1, p: 1'b1};
        else        st_q <= st_d;
    end

    assign t_o = st_q.t;
    assign p_o = st_q.p;
endmodule

// File: rtl/status_rw_fields.sv
module status_rw_fields
    import status_word_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_i,
    input  logic              ext_rst_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              alu_we_i,
    input  logic [FLAG_W-1:0] alu_flags_i,
    output logic [WORD_W-1:0] rw_word_o
);
    stat_word_t word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (alu_we_i) word_d.zdc_c = alu_flags_i;
        if (wr_en_i)  word_d = stat_word_t'(wr_data_i & RW_MASK);
        if (ext_rst_i) begin
            word_d.rpage  = '0;
            word_d.iopage = 1'b0;
        end
        if (por_i) word_d = '0;
        word_d.t = 1'b0;
        word_d.p = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign rw_word_o = word_q;
endmodule

// File: rtl/status_word_reg.sv
module status_word_reg
    import status_word_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_i,
    input  logic              wdt_to_i,
    input  logic              ext_rst_i,
    input  logic              slp_exec_i,
    input  logic              wdtc_exec_i,
    input  logic              asleep_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              alu_we_i,
    input  logic [FLAG_W-1:0] alu_flags_i,
    output logic [WORD_W-1:0] rd_data_o
);
    logic              t_flag;
    logic              p_flag;
    logic [WORD_W-1:0] rw_word;

    status_wake_flags u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .por_i      (por_i),
        .wdt_to_i   (wdt_to_i),
        .ext_rst_i  (ext_rst_i),
        .slp_exec_i (slp_exec_i),
        .wdtc_exec_i(wdtc_exec_i),
        .asleep_i   (asleep_i),
        .t_o        (t_flag),
        .p_o        (p_flag)
    );

    status_rw_fields u_rw (
        .clk        (clk),
        .rst_n      (rst_n),
        .por_i      (por_i),
        .ext_rst_i  (ext_rst_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .alu_we_i   (alu_we_i),
        .alu_flags_i(alu_flags_i),
        .rw_word_o  (rw_word)
    );

    always_comb begin
        rd_data_o          = rw_word;
        rd_data_o[T_POS]   = t_flag;
        rd_data_o[P_POS]   = p_flag;
    end
endmodule

// File: rtl/status_word_chk.sv
module status_word_chk
    import status_word_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              por_i,
    input logic              wdt_to_i,
    input logic              ext_rst_i,
    input logic              slp_exec_i,
    input logic              wdtc_exec_i,
    input logic              asleep_i,
    input logic              wr_en_i,
    input logic [WORD_W-1:0] wr_data_i,
    input logic              alu_we_i,
    input logic [FLAG_W-1:0] alu_flags_i,
    input logic [WORD_W-1:0] rd_data_o
);
    assert_por_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        por_i |=> rd_data_o == TP_RESET);

    assert_wdt_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_to_i && !por_i) |=> (rd_data_o[T_POS] == 1'b0) && (rd_data_o[P_POS] == !$past(asleep_i)));

    assert_pin_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rst_i && asleep_i && !por_i && !wdt_to_i) |=> rd_data_o[T_POS] && !rd_data_o[P_POS]);

    assert_pin_awake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rst_i && !asleep_i && !por_i && !wdt_to_i) |=> $stable(rd_data_o[T_POS:P_POS]));

    assert_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slp_exec_i && !por_i && !wdt_to_i && !ext_rst_i) |=> rd_data_o[T_POS] && !rd_data_o[P_POS]);

    assert_wdtc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wdtc_exec_i && !slp_exec_i && !por_i && !wdt_to_i && !ext_rst_i) |=> rd_data_o[T_POS] && rd_data_o[P_POS]);

    assert_write_keeps_tp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !por_i && !wdt_to_i && !ext_rst_i && !slp_exec_i && !wdtc_exec_i) |=> $stable(rd_data_o[T_POS:P_POS]));

    assert_write_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !por_i) |=> rd_data_o[FLAG_W-1:0] == $past(wr_data_i[FLAG_W-1:0]));

    assert_alu_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_we_i && !wr_en_i && !por_i) |=> rd_data_o[FLAG_W-1:0] == $past(alu_flags_i));

    assert_pin_pages_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst_i |=> rd_data_o[WORD_W-1:T_POS+1] == '0);
endmodule

bind status_word_reg status_word_chk u_status_word_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_i      (por_i),
    .wdt_to_i   (wdt_to_i),
    .ext_rst_i  (ext_rst_i),
    .slp_exec_i (slp_exec_i),
    .wdtc_exec_i(wdtc_exec_i),
    .asleep_i   (asleep_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .alu_we_i   (alu_we_i),
    .alu_flags_i(alu_flags_i),
    .rd_data_o  (rd_data_o)
);

// File: tb/test_status_word_reg.sv
`timescale 1ns/1ps
module test_status_word_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_i = 0, wdt_to_i = 0, ext_rst_i = 0, slp_exec_i = 0, wdtc_exec_i = 0, asleep_i = 0;
    logic       wr_en_i = 0, alu_we_i = 0;
    logic [7:0] wr_data_i = '0;
    logic [2:0] alu_flags_i = '0;
    logic [7:0] rd_data_o;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 0;
    logic [7:0] model;

    always #2.5 clk = ~clk;

    status_word_reg i_status_word_reg (.*);

    function automatic logic [7:0] next_word(
        logic [7:0] cur, bit por, bit wdt, bit ext, bit slp, bit wdtc, bit asl,
        bit we, logic [7:0] wd, bit awe, logic [2:0] af);
        logic [7:0] n;
        n = cur;
        if (awe) n[2:0] = af;
        if (we) begin n[7:5] = wd[7:5]; n[2:0] = wd[2:0]; end
        if (ext) n[7:5] = 3'b000;
        if (por) n = 8'h18;
        else if (wdt) begin n[4] = 1'b0; n[3] = ~asl; end
        else if (ext) begin if (asl) begin n[4] = 1'b1; n[3] = 1'b0; end end
        else if (slp) begin n[4] = 1'b1; n[3] = 1'b0; end
        else if (wdtc) begin n[4] = 1'b1; n[3] = 1'b1; end
        return n;
    endfunction

    task automatic check(string req, logic [7:0] exp);
        n_vec++;
        if (rd_data_o !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, rd_data_o, exp);
        end
    endtask

    task automatic step(bit por, bit wdt, bit ext, bit slp, bit wdtc, bit asl,
                        bit we, logic [7:0] wd, bit awe, logic [2:0] af, string req);
        por_i = por; wdt_to_i = wdt; ext_rst_i = ext; slp_exec_i = slp; wdtc_exec_i = wdtc;
        asleep_i = asl; wr_en_i = we; wr_data_i = wd; alu_we_i = awe; alu_flags_i = af;
        model = next_word(model, por, wdt, ext, slp, wdtc, asl, we, wd, awe, af);
        @(posedge clk);
        @(negedge clk);
        check(req, model);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model = 8'h18;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", 8'h18);
        // R9 write all ones, R8 T/P untouched
        step(0,0,0,0,0,0, 1,8'hE7, 0,3'b0, "R9 write");
        step(0,0,0,0,0,0, 1,8'h18, 0,3'b0, "R8 write of T/P bits");
        step(0,0,0,0,0,0, 0,8'h00, 1,3'b101, "R10 alu");
        step(0,0,0,0,0,0, 1,8'h02, 1,3'b101, "R10 write beats alu");
        step(0,0,0,0,0,0, 1,8'hE0, 0,3'b0, "R9 pages");
        step(0,1,0,0,0,0, 0,8'h00, 0,3'b0, "R2 wdt awake");
        step(0,0,0,0,1,0, 0,8'h00, 0,3'b0, "R6 wdtc");
        step(0,0,0,1,0,0, 0,8'h00, 0,3'b0, "R5 sleep");
        step(0,1,0,0,0,1, 0,8'h00, 0,3'b0, "R2 wdt asleep");
        step(0,0,0,1,0,1, 1,8'hA5, 0,3'b0, "R5 sleep again");
        step(0,0,1,0,0,1, 1,8'hE7, 0,3'b0, "R3 pin wake and R11 pages");
        step(0,0,0,0,1,0, 0,8'h00, 0,3'b0, "R6 wdtc");
        step(0,0,1,1,1,0, 0,8'h00, 1,3'b010, "R4 pin awake blocks instr");
        step(0,1,1,1,1,0, 1,8'hFF, 0,3'b0, "R7 wdt over pin");
        step(0,0,0,1,1,0, 0,8'h00, 0,3'b0, "R7 sleep over wdtc");
        step(1,1,1,1,1,1, 1,8'hFF, 1,3'b111, "R1 por over all");
        step(0,0,1,0,0,0, 1,8'hE7, 0,3'b0, "R11 pin keeps flags");
        for (int i = 0; i < 4000; i++) begin
            bit por, wdt, ext, slp, wdtc, asl, we, awe;
            string tag;
            por  = ($urandom % 64) == 0;
            wdt  = ($urandom % 10) == 0;
            ext  = ($urandom % 10) == 0;
            slp  = ($urandom % 6) == 0;
            wdtc = ($urandom % 6) == 0;
            asl  = $urandom % 2;
            we   = ($urandom % 3) == 0;
            awe  = ($urandom % 3) == 0;
            if (por) tag = "R1 R7 random por";
            else if (wdt) tag = "R2 R7 random wdt";
            else if (ext) tag = asl ? "R3 random pin" : "R4 random pin";
            else if (slp) tag = "R5 random sleep";
            else if (wdtc) tag = "R6 random wdtc";
            else if (we) tag = "R8 R9 random write";
            else tag = "R10 random alu";
            step(por, wdt, ext, slp, wdtc, asl, we, 8'($urandom), awe, 3'($urandom), tag);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule